// File: doc/BRIEF.md
# I2C Slave Receiver with Masked Address Recognition

This block listens on a pair of I2C lines and acts as a write-only target. It can answer up to four configurable addresses. Each address comes with its own mask, and a mask bit of 1 removes the matching address bit from the compare. It can also answer the all-zero broadcast (General Call) address. Data bytes from a master transmitter are shifted in and acknowledged. After every relevant bus event the block raises an interrupt flag and publishes a status code. A service routine reads that code, acts on it and then clears the flag.

Control is held in an 8-bit register. It is written through a set port, where a 1 sets a bit, and a clear port, where a 1 clears a bit. While the flag is raised after an address or data byte, the block holds SCL low, so the master waits for software. Clearing the assert-acknowledge bit cuts the block off from the bus: incoming bytes are answered with NACK and addresses are ignored. The block keeps tracking the traffic while it is cut off. A lost-arbitration input from a master elsewhere on the chip selects the alternate address status codes. The bus clock rate has no influence on the block, because both lines are oversampled by the system clock.

Top module: `i2c_slv_rx`

## Requirements
- R1: After reset the control register reads 0x00, the status output reads 0xF8, the interrupt output is low, and neither SDA nor SCL is driven.
- R2: Control bit positions are: enable bit 6, start bit 5, stop bit 4, interrupt flag bit 3, assert-acknowledge bit 2. Bits 7, 1 and 0 always read 0. Software cannot set the interrupt flag through the set port. The flag stays set until the clear port writes a 1 to bit 3.
- R3: When enable and assert-acknowledge are both set, an address byte (7-bit address in bits 7..1, direction in bit 0) with direction 0 is accepted if it equals any of the four slot addresses on every bit whose mask bit is 0. On acceptance the block pulls SDA low during the 9th clock, raises the flag and reports 0x60.
- R4: With the broadcast enable input high, address 0x00 with direction 0 is accepted, acknowledged and reported as 0x70.
- R5: An address that matches no slot, or that carries direction 1, gets no ACK and no flag. All bytes up to the next start condition are then ignored.
- R6: A data byte received while addressed appears on the received-data output. It raises the flag and reports 0x80 (own address) or 0x90 (broadcast), and is acknowledged when assert-acknowledge is set.
- R7: If assert-acknowledge is clear when a data byte completes, the byte is still captured. It is reported as 0x88 (own address) or 0x98 (broadcast) and answered with NACK. The block is then no longer addressed, and later bytes get no ACK and no flag.
- R8: While assert-acknowledge is clear, own and broadcast addresses get no ACK and no flag. Setting the bit again restores address recognition at the next start.
- R9: When the lost-arbitration input is high as an address is accepted, the status is 0x68 (own address) or 0x78 (broadcast) instead of 0x60 or 0x70.
- R10: A stop or repeated start condition while the block is addressed raises the flag and reports 0xA0, without holding SCL.
- R11: After SCL falls at the end of an accepted address byte or data byte with the flag set, the block holds SCL low until the flag is cleared. While the flag is clear, the status output reads 0xF8.
- R12: With enable clear the block drives neither line, raises no flag and acknowledges nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low (ACK) |
| set_we_i | input | 1 | Strobe for the control set port |
| set_bits_i | input | 8 | Control bits to set |
| clr_we_i | input | 1 | Strobe for the control clear port |
| clr_bits_i | input | 8 | Control bits to clear |
| slot_adr_i | input | SLOTS x AW (4x7) | Slot addresses |
| slot_msk_i | input | SLOTS x AW (4x7) | Slot masks, 1 = don't care |
| gc_en_i | input | 1 | Enables broadcast address 0x00 |
| arb_lost_i | input | 1 | Lost-arbitration indication from a master |
| ctl_o | output | 8 | Control register contents |
| stat_o | output | 8 | Status code |
| irq_o | output | 1 | Interrupt flag |
| rx_data_o | output | 8 | Last received data byte |

## Verification
Some rules are checked by assertions on every cycle:
- SDA is only pulled low inside an acknowledge phase, and never when a NACK is due.
- A clock stretch ends once the flag has been cleared.
- The flag neither appears on its own nor disappears without a clear write.
- A disabled block stays silent.

Other behaviour only the bench scenarios can show: the masked compare across the slots, the exact status code for each event order, the ACK seen by a bit-banged master, the captured data value, and the effect of toggling assert-acknowledge in the middle of a transfer.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  // control register bit positions
  localparam int CTL_EN  = 6;
  localparam int CTL_STA = 5;
  localparam int CTL_STO = 4;
  localparam int CTL_SI  = 3;
  localparam int CTL_AA  = 2;

  // status codes
  localparam logic [7:0] ST_OWN_W     = 8'h60;
  localparam logic [7:0] ST_OWN_W_ARB = 8'h68;
  localparam logic [7:0] ST_GC_W      = 8'h70;
  localparam logic [7:0] ST_GC_W_ARB  = 8'h78;
  localparam logic [7:0] ST_OWN_DACK  = 8'h80;
  localparam logic [7:0] ST_OWN_DNACK = 8'h88;
  localparam logic [7:0] ST_GC_DACK   = 8'h90;
  localparam logic [7:0] ST_GC_DNACK  = 8'h98;
  localparam logic [7:0] ST_STOP      = 8'hA0;
  localparam logic [7:0] ST_NONE      = 8'hF8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_DATA,
    S_DACK,
    S_SKIP
  } rx_state_e;

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int TOP = STAGES;

  logic [TOP:0] scl_sh_q, scl_sh_d;
  logic [TOP:0] sda_sh_q, sda_sh_d;

  always_comb begin
    scl_sh_d = {scl_sh_q[TOP-1:0], scl_i};
    sda_sh_d = {sda_sh_q[TOP-1:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
    end else begin
      scl_sh_q <= scl_sh_d;
      sda_sh_q <= sda_sh_d;
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_sh_q[TOP-1];
  assign scl_old = scl_sh_q[TOP];
  assign sda_now = sda_sh_q[TOP-1];
  assign sda_old = sda_sh_q[TOP];

  assign scl_o      = scl_now;
  assign sda_o      = sda_now;
  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int SLOTS = 4,
  parameter int AW    = 7
) (
  input  logic [AW-1:0]            addr_i,
  input  logic [SLOTS-1:0][AW-1:0] slot_adr_i,
  input  logic [SLOTS-1:0][AW-1:0] slot_msk_i,
  input  logic                     gc_en_i,
  output logic                     own_hit_o,
  output logic                     gc_hit_o
);

  logic [SLOTS-1:0] hit;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign hit[g] = (((addr_i ^ slot_adr_i[g]) & ~slot_msk_i[g]) == '0);
  end

  // the broadcast address takes priority over a slot that also matches zero
  assign gc_hit_o  = gc_en_i && (addr_i == '0);
  assign own_hit_o = (|hit) && !gc_hit_o;

endmodule

// File: rtl/i2c_slv_ctl.sv
module i2c_slv_ctl
  import i2c_slv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_we_i,
  input  logic [7:0] set_bits_i,
  input  logic       clr_we_i,
  input  logic [7:0] clr_bits_i,
  input  logic       si_set_i,
  output logic [7:0] ctl_o
);

  localparam logic [7:0] SET_MASK = (8'h1 << CTL_EN) | (8'h1 << CTL_STA) |
                                    (8'h1 << CTL_STO) | (8'h1 << CTL_AA);
  localparam logic [7:0] CLR_MASK = SET_MASK | (8'h1 << CTL_SI);

  logic [7:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (set_we_i) ctl_d = ctl_d | (set_bits_i & SET_MASK);
    if (clr_we_i) ctl_d = ctl_d & ~(clr_bits_i & CLR_MASK);
    // a hardware event wins over a simultaneous clear so it is never lost
    if (si_set_i) ctl_d[CTL_SI] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  p_si_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[CTL_SI] && !(clr_we_i && clr_bits_i[CTL_SI])) |=> ctl_q[CTL_SI]);

  p_si_no_sw_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[CTL_SI] && !si_set_i) |=> !ctl_q[CTL_SI]);

endmodule

// File: rtl/i2c_slv_rx.sv
module i2c_slv_rx
  import i2c_slv_pkg::*;
#(
  parameter int SLOTS       = 4,
  parameter int AW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     scl_oe_o,
  output logic                     sda_oe_o,
  input  logic                     set_we_i,
  input  logic [7:0]               set_bits_i,
  input  logic                     clr_we_i,
  input  logic [7:0]               clr_bits_i,
  input  logic [SLOTS-1:0][AW-1:0] slot_adr_i,
  input  logic [SLOTS-1:0][AW-1:0] slot_msk_i,
  input  logic                     gc_en_i,
  input  logic                     arb_lost_i,
  output logic [7:0]               ctl_o,
  output logic [7:0]               stat_o,
  output logic                     irq_o,
  output logic [7:0]               rx_data_o
);

  localparam int BW = AW + 1;           // address plus direction bit
  localparam int CW = $clog2(BW);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= '0;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  logic rst_s_n;
  assign rst_s_n = rst_sh_q[1];

  // bus line sampling
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  // control register
  logic       si_set;
  logic [7:0] ctl;

  i2c_slv_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .set_we_i   (set_we_i),
    .set_bits_i (set_bits_i),
    .clr_we_i   (clr_we_i),
    .clr_bits_i (clr_bits_i),
    .si_set_i   (si_set),
    .ctl_o      (ctl)
  );

  logic en, aa, si;
  assign en = ctl[CTL_EN];
  assign aa = ctl[CTL_AA];
  assign si = ctl[CTL_SI];

  // receive state
  rx_state_e     state_q, state_d;
  logic [CW-1:0] bit_cnt_q, bit_cnt_d;
  logic [BW-1:0] shreg_q, shreg_d;
  logic [7:0]    rx_q, rx_d;
  logic [7:0]    stat_q, stat_d;
  logic          gc_q, gc_d;
  logic          ack_q, ack_d;
  logic          ack9_q, ack9_d;
  logic          sda_oe_q, sda_oe_d;
  logic          stretch_q, stretch_d;

  logic [BW-1:0] byte_nx;
  logic          last_bit;
  assign byte_nx  = {shreg_q[BW-2:0], sda_s};
  assign last_bit = (bit_cnt_q == CW'(BW - 1));

  // address compare
  logic own_hit, gc_hit;

  i2c_addr_match #(.SLOTS(SLOTS), .AW(AW)) u_match (
    .addr_i     (byte_nx[BW-1:1]),
    .slot_adr_i (slot_adr_i),
    .slot_msk_i (slot_msk_i),
    .gc_en_i    (gc_en_i),
    .own_hit_o  (own_hit),
    .gc_hit_o   (gc_hit)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    bit_cnt_d = bit_cnt_q;
    shreg_d   = shreg_q;
    rx_d      = rx_q;
    stat_d    = stat_q;
    gc_d      = gc_q;
    ack_d     = ack_q;
    ack9_d    = ack9_q;
    sda_oe_d  = sda_oe_q;
    stretch_d = stretch_q;
    si_set    = 1'b0;

    if (!en) begin
      state_d   = S_IDLE;
      bit_cnt_d = '0;
      sda_oe_d  = 1'b0;
      stretch_d = 1'b0;
    end else if (start_det || stop_det) begin
      if (state_q == S_DATA || state_q == S_DACK) begin
        si_set = 1'b1;
        stat_d = ST_STOP;
      end
      state_d   = start_det ? S_ADDR : S_IDLE;
      bit_cnt_d = '0;
      sda_oe_d  = 1'b0;
      stretch_d = 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR: begin
          if (scl_rise) begin
            shreg_d   = byte_nx;
            bit_cnt_d = bit_cnt_q + CW'(1);
            if (last_bit) begin
              bit_cnt_d = '0;
              if (aa && !byte_nx[0] && (own_hit || gc_hit)) begin
                state_d = S_AACK;
                ack_d   = 1'b1;
                ack9_d  = 1'b0;
                gc_d    = gc_hit;
                si_set  = 1'b1;
                if (gc_hit) stat_d = arb_lost_i ? ST_GC_W_ARB  : ST_GC_W;
                else        stat_d = arb_lost_i ? ST_OWN_W_ARB : ST_OWN_W;
              end else begin
                state_d = S_SKIP;
              end
            end
          end
        end
        S_DATA: begin
          if (scl_rise) begin
            shreg_d   = byte_nx;
            bit_cnt_d = bit_cnt_q + CW'(1);
            if (last_bit) begin
              bit_cnt_d = '0;
              rx_d      = byte_nx;
              ack_d     = aa;
              ack9_d    = 1'b0;
              state_d   = S_DACK;
              si_set    = 1'b1;
              if (gc_q) stat_d = aa ? ST_GC_DACK  : ST_GC_DNACK;
              else      stat_d = aa ? ST_OWN_DACK : ST_OWN_DNACK;
            end
          end
        end
        S_AACK, S_DACK: begin
          if (scl_fall) begin
            if (!ack9_q) begin
              ack9_d    = 1'b1;
              sda_oe_d  = ack_q;
              stretch_d = si;
            end else begin
              sda_oe_d  = 1'b0;
              bit_cnt_d = '0;
              state_d   = (state_q == S_AACK || ack_q) ? S_DATA : S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end

    if (!si) stretch_d = 1'b0;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q   <= S_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      rx_q      <= '0;
      stat_q    <= ST_NONE;
      gc_q      <= 1'b0;
      ack_q     <= 1'b0;
      ack9_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
      stretch_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      bit_cnt_q <= bit_cnt_d;
      shreg_q   <= shreg_d;
      rx_q      <= rx_d;
      stat_q    <= stat_d;
      gc_q      <= gc_d;
      ack_q     <= ack_d;
      ack9_q    <= ack9_d;
      sda_oe_q  <= sda_oe_d;
      stretch_q <= stretch_d;
    end
  end

  assign ctl_o     = ctl;
  assign irq_o     = si;
  assign stat_o    = si ? stat_q : ST_NONE;
  assign sda_oe_o  = sda_oe_q;
  assign scl_oe_o  = stretch_q;
  assign rx_data_o = rx_q;

  // checks
  p_sda_in_ack_phase_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    sda_oe_q |-> (state_q == S_AACK || state_q == S_DACK));

  p_no_ack_on_nack_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == S_DACK && !ack_q) |-> !sda_oe_q);

  p_stretch_release_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (stretch_q && !si) |=> !stretch_q);

  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    !en |=> (!sda_oe_q && !stretch_q && state_q == S_IDLE));

  p_skip_silent_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == S_SKIP && !start_det && !stop_det) |=> !si_set_q_helper);

  logic si_set_q_helper;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) si_set_q_helper <= 1'b0;
    else          si_set_q_helper <= si_set && (state_q == S_SKIP);
  end

endmodule

// File: tb/i2c_slv_rx_tb_top.sv
module i2c_slv_rx_tb_top;

  localparam int Q = 8;   // clocks per quarter of a bus bit

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  logic scl_bus, sda_bus;
  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  logic       set_we = 1'b0, clr_we = 1'b0;
  logic [7:0] set_bits = '0, clr_bits = '0;
  logic [3:0][6:0] slot_adr, slot_msk;
  logic gc_en = 1'b1, arb_lost = 1'b0;
  logic [7:0] ctl, stat, rx_data;
  logic irq;

  i2c_slv_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .set_we_i(set_we), .set_bits_i(set_bits),
    .clr_we_i(clr_we), .clr_bits_i(clr_bits),
    .slot_adr_i(slot_adr), .slot_msk_i(slot_msk),
    .gc_en_i(gc_en), .arb_lost_i(arb_lost),
    .ctl_o(ctl), .stat_o(stat), .irq_o(irq), .rx_data_o(rx_data)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic wr_set(input logic [7:0] v);
    @(negedge clk); set_we = 1'b1; set_bits = v;
    @(negedge clk); set_we = 1'b0; set_bits = '0;
  endtask

  task automatic wr_clr(input logic [7:0] v);
    @(negedge clk); clr_we = 1'b1; clr_bits = v;
    @(negedge clk); clr_we = 1'b0; clr_bits = '0;
  endtask

  // scoreboard monitor: each rising interrupt pops one expected status
  logic irq_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && irq && !irq_prev) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL unexpected interrupt: actual status 0x%02h expected none", stat);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, "status code", stat, e);
      end
    end
    irq_prev = irq;
  end

  task automatic push_exp(input logic [7:0] st, input string req);
    exp_q.push_back(st);
    tag_q.push_back(req);
  endtask

  task automatic m_start();
    sda_m = 1'b1; scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic m_rstart(input bit exp_irq, input string req);
    if (exp_irq) push_exp(8'hA0, req);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; wait_scl_high(); tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(2*Q);
    if (exp_irq) wr_clr(8'h08);
  endtask

  task automatic m_stop(input bit exp_irq, input string req);
    if (exp_irq) push_exp(8'hA0, req);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; wait_scl_high(); tick(Q);
    sda_m = 1'b1; tick(2*Q);
    if (exp_irq) begin
      chk(req, "no stretch on stop", {7'd0, scl_oe}, 8'd0);
      wr_clr(8'h08);
    end
  endtask

  task automatic m_byte(input logic [7:0] b, input bit exp_irq,
                        input logic [7:0] exp_st, input bit exp_ack,
                        input bit chk_rx, input string req);
    logic ack;
    if (exp_irq) push_exp(exp_st, req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; wait_scl_high(); tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    if (chk_rx) chk(req, "received data", rx_data, b);
    if (exp_irq) begin
      chk("R11", "SCL held while flag set", {7'd0, scl_oe}, 8'd1);
      wr_clr(8'h08);
    end
    scl_m = 1'b1; wait_scl_high(); tick(Q/2);
    ack = ~sda_bus;
    tick(Q/2);
    scl_m = 1'b0; tick(Q);
    chk(req, "acknowledge", {7'd0, ack}, {7'd0, exp_ack});
  endtask

  initial begin
    slot_adr[0] = 7'h2A; slot_msk[0] = 7'h00;
    slot_adr[1] = 7'h11; slot_msk[1] = 7'h00;
    slot_adr[2] = 7'h50; slot_msk[2] = 7'h0F;
    slot_adr[3] = 7'h7F; slot_msk[3] = 7'h00;
    tick(4);
    rst_n = 1'b1;
    tick(5);

    // R1 reset state
    chk("R1", "control after reset", ctl, 8'h00);
    chk("R1", "status after reset", stat, 8'hF8);
    chk("R1", "lines undriven", {6'd0, scl_oe, sda_oe}, 8'h00);
    chk("R1", "flag low", {7'd0, irq}, 8'h00);

    // R2 control bits: only EN/STA/STO/AA settable
    wr_set(8'hFF);
    chk("R2", "set all", ctl, 8'h74);
    wr_clr(8'h30);
    chk("R2", "clear start/stop", ctl, 8'h44);

    // R3 R6 R10 exact slot, two data bytes, stop
    m_start();
    m_byte(8'h54, 1, 8'h60, 1, 0, "R3");
    m_byte(8'hA5, 1, 8'h80, 1, 1, "R6");
    m_byte(8'h3C, 1, 8'h80, 1, 1, "R6");
    m_stop(1, "R10");
    chk("R11", "status with flag clear", stat, 8'hF8);

    // R3 masked slot, R10 repeated start, slot 3
    m_start();
    m_byte(8'hB6, 1, 8'h60, 1, 0, "R3");
    m_byte(8'h01, 1, 8'h80, 1, 1, "R6");
    m_rstart(1, "R10");
    m_byte(8'hFE, 1, 8'h60, 1, 0, "R3");
    m_stop(1, "R10");

    // R5 read direction and unmatched address
    m_start();
    m_byte(8'h55, 0, 8'h00, 0, 0, "R5");
    m_byte(8'h12, 0, 8'h00, 0, 0, "R5");
    m_stop(0, "R5");
    m_start();
    m_byte(8'h66, 0, 8'h00, 0, 0, "R5");
    m_stop(0, "R5");

    // R4 broadcast, R7 acknowledge withdrawn mid-transfer
    m_start();
    m_byte(8'h00, 1, 8'h70, 1, 0, "R4");
    m_byte(8'h77, 1, 8'h90, 1, 1, "R6");
    wr_clr(8'h04);
    m_byte(8'h88, 1, 8'h98, 0, 1, "R7");
    m_byte(8'h99, 0, 8'h00, 0, 0, "R7");
    m_stop(0, "R7");

    // R8 isolated, then restored
    m_start();
    m_byte(8'h54, 0, 8'h00, 0, 0, "R8");
    m_stop(0, "R8");
    wr_set(8'h04);
    m_start();
    m_byte(8'h54, 1, 8'h60, 1, 0, "R8");
    m_stop(1, "R8");

    // R9 lost arbitration
    arb_lost = 1'b1;
    m_start();
    m_byte(8'h54, 1, 8'h68, 1, 0, "R9");
    m_stop(1, "R9");
    m_start();
    m_byte(8'h00, 1, 8'h78, 1, 0, "R9");
    arb_lost = 1'b0;
    m_byte(8'h42, 1, 8'h90, 1, 1, "R9");
    m_stop(1, "R9");

    // R12 disabled
    wr_clr(8'h40);
    chk("R12", "control after disable", ctl, 8'h04);
    m_start();
    m_byte(8'h54, 0, 8'h00, 0, 0, "R12");
    m_stop(0, "R12");
    chk("R12", "flag stays low", {7'd0, irq}, 8'h00);

    tick(10);
    chk("R1", "pending expected events", 8'(exp_q.size()), 8'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule